// File: doc/BRIEF.md
# Multi-Channel Command Block Walker

This block processes a 64-byte command block held in a byte-wide RAM that sits outside it. The block is made of back-to-back frames. Each frame holds a transmit count, a receive count, the transmit bytes, and then room for the reply. On a start pulse the walker first checks a gate value in the final byte. It then steps through the frames and gives each active frame a channel number that depends on where the frame sits. It runs the frame's command and writes the reply bytes back in place, directly after the transmit bytes.

Status requests, and button reads on channel 0, are answered by logic inside the block. Commands from a configurable external code range are handed to device models outside the block. Before the request pulse, the walker streams the frame's transmit bytes to the device side. The device then returns a verdict, and the walker fetches the reply bytes from it by index. When a command fails, the walker writes no reply. Instead it marks the failure in the frame's receive count byte. The walk ends by clearing the top bit of the final byte.

Top module: `cmdblk_walker`

## Requirements
- R1: On start, the walker reads byte 63. If that byte is not 0x01, it writes nothing to the RAM and pulses `done`.
- R2: Frames are parsed only while the parse pointer is below 63. Each frame begins with its transmit count byte. A pointer that reaches 63 ends the walk.
- R3: A transmit count byte of 0xFE ends the walk at once. So does a receive count byte of 0xFE.
- R4: A transmit count byte that has bit 7 set and is not 0xFE is skipped as a single byte. The channel number does not change.
- R5: A transmit count of 0x00, or one with bit 6 set, moves to the next channel. No command runs.
- R6: When a command succeeds, its reply bytes go to the addresses directly after the transmit bytes, and the pointer moves past them. The reply length is bits 5:0 of the receive count byte.
- R7: When a command fails, bit 7 is ORed into the frame's receive count byte and the reply area is left untouched. The next frame starts directly after the transmit bytes.
- R8: A command byte of 0x00 or 0xFF is a status request. A present channel gets 0x05, 0x00, then 0x01 if an accessory is fitted or 0x00 if not. Bytes past the third are 0x00. An absent channel fails.
- R9: Channel 0 always counts as present. Command 0x01 on channel 0 returns the button word most significant byte first, and 0x00 past its width. Command 0x01 on any other channel fails.
- R10: For a command byte from 0x02 to 0x08 on a channel below NUM_CH, the walker streams the transmit bytes and then pulses `dev_req` for one cycle, carrying the channel, command and both lengths. It waits for `dev_done`, uses `dev_ok` as the verdict, and takes reply byte k from `dev_rx_byte` while `dev_rx_idx` is k.
- R11: Any other command code fails, and so does any command on a channel at or above NUM_CH.
- R12: When a walk that passed the gate ends, byte 63 is rewritten with bit 7 cleared, and then `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| ram_addr | output | 6 | RAM byte address |
| ram_rd | output | 1 | Read request; data returns the next cycle |
| ram_wr | output | 1 | Byte write strobe |
| ram_wdata | output | 8 | Write data |
| ram_rdata | input | 8 | Read data, one cycle after `ram_rd` |
| pad_present | input | NUM_CH | Per-channel presence |
| accessory | input | NUM_CH | Per-channel accessory fitted |
| buttons | input | 8*BTN_BYTES | Current button word |
| dev_tx_valid | output | 1 | Transmit byte valid |
| dev_tx_byte | output | 8 | Transmit byte of the current frame |
| dev_req | output | 1 | External command request pulse |
| dev_chan | output | 6 | Channel of the request |
| dev_cmd | output | 8 | Command byte |
| dev_tx_len | output | 6 | Transmit count |
| dev_rx_len | output | 6 | Reply count |
| dev_done | input | 1 | Device verdict valid |
| dev_ok | input | 1 | Device verdict: success |
| dev_rx_idx | output | 6 | Index of the reply byte wanted |
| dev_rx_byte | input | 8 | Reply byte at `dev_rx_idx` |

## Verification
The RAM has one cycle of read latency, so each frame costs two cycles per header or transmit byte and one cycle per reply byte. `dev_req` rises in the cycle after the last transmit byte has been streamed. The bench device raises `dev_done` three cycles after it sees the request, and the monitor compares each request against its expected queue at the falling edge of the cycle in which the request is high. The final image is checked only after `done` is seen at a falling edge. By then the gate-byte rewrite, which happens in the cycle before `done`, has reached the RAM model.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
   localparam logic [7:0] STOP_CODE   = 8'hFE;
   localparam logic [7:0] GATE_CODE   = 8'h01;
   localparam logic [7:0] CMD_STATUS  = 8'h00;
   localparam logic [7:0] CMD_RESET   = 8'hFF;
   localparam logic [7:0] CMD_BUTTONS = 8'h01;
   localparam logic [7:0] FAIL_MARK   = 8'h80;

   typedef enum logic [1:0] {
      LEN_STOP,
      LEN_SKIP,
      LEN_EMPTY,
      LEN_FRAME
   } len_class_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CTL_RD, S_CTL_WT, S_HDR_RD, S_HDR_WT, S_RXL_WT,
      S_TX_RD, S_TX_WT, S_EXEC, S_DEV_WT, S_REPLY, S_FAIL,
      S_FIN_RD, S_FIN_WT, S_DONE
   } walk_state_e;
endpackage

// File: rtl/cbw_len_classify.sv
module cbw_len_classify
   import cbw_pkg::*;
(
   input  logic [7:0] len_byte,
   output len_class_e cls
);
   always_comb begin
      if (len_byte == STOP_CODE)                  cls = LEN_STOP;
      else if (len_byte[7])                       cls = LEN_SKIP;
      else if (len_byte == 8'h00 || len_byte[6])  cls = LEN_EMPTY;
      else                                        cls = LEN_FRAME;
   end
endmodule

// File: rtl/cbw_builtin.sv
module cbw_builtin
   import cbw_pkg::*;
#(
   parameter int         NUM_CH     = 5,
   parameter int         CH_W       = 6,
   parameter int         IDX_W      = 6,
   parameter int         BTN_BYTES  = 4,
   parameter bit         CH0_FORCED = 1'b1,
   parameter logic [7:0] ID_BYTE0   = 8'h05,
   parameter logic [7:0] ID_BYTE1   = 8'h00
) (
   input  logic [CH_W-1:0]        chan,
   input  logic [7:0]             cmd,
   input  logic [IDX_W-1:0]       idx,
   input  logic [NUM_CH-1:0]      pad_present,
   input  logic [NUM_CH-1:0]      accessory,
   input  logic [8*BTN_BYTES-1:0] buttons,
   output logic                   is_builtin,
   output logic                   ok,
   output logic [7:0]             reply_byte
);
   if (NUM_CH < 1 || NUM_CH > (1 << CH_W) - 1) begin : g_bad_ch
      $error("cbw_builtin: NUM_CH out of range");
   end
   if (BTN_BYTES < 1 || BTN_BYTES > 8) begin : g_bad_btn
      $error("cbw_builtin: BTN_BYTES out of range");
   end

   logic [NUM_CH-1:0] present_eff;
   for (genvar g = 0; g < NUM_CH; g++) begin : g_present
      if (g == 0 && CH0_FORCED) begin : g_forced
         assign present_eff[g] = 1'b1;
      end else begin : g_pin
         assign present_eff[g] = pad_present[g];
      end
   end

   logic ch_present, ch_acc;
   always_comb begin
      ch_present = 1'b0;
      ch_acc     = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (int'(chan) == i) begin
            ch_present = present_eff[i];
            ch_acc     = accessory[i];
         end
      end
   end

   logic [7:0] btn_byte;
   always_comb begin
      btn_byte = 8'h00;
      for (int i = 0; i < BTN_BYTES; i++) begin
         if (int'(idx) == i) btn_byte = buttons[8*(BTN_BYTES-1-i) +: 8];
      end
   end

   logic is_status, is_btn;
   assign is_status  = (cmd == CMD_STATUS) || (cmd == CMD_RESET);
   assign is_btn     = (cmd == CMD_BUTTONS);
   assign is_builtin = is_status || is_btn;

   always_comb begin
      ok         = 1'b0;
      reply_byte = 8'h00;
      if (is_status) begin
         ok = ch_present;
         case (int'(idx))
            0:       reply_byte = ID_BYTE0;
            1:       reply_byte = ID_BYTE1;
            2:       reply_byte = {7'b0, ch_acc};
            default: reply_byte = 8'h00;
         endcase
      end else if (is_btn) begin
         ok         = (chan == '0);
         reply_byte = btn_byte;
      end
   end
endmodule

// File: rtl/cmdblk_walker.sv
module cmdblk_walker
   import cbw_pkg::*;
#(
   parameter int         NUM_CH     = 5,
   parameter int         BTN_BYTES  = 4,
   parameter int         EXT_LO     = 2,
   parameter int         EXT_HI     = 8,
   parameter bit         CH0_FORCED = 1'b1,
   parameter logic [7:0] ID_BYTE0   = 8'h05,
   parameter logic [7:0] ID_BYTE1   = 8'h00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   output logic                   busy,
   output logic                   done,
   output logic [5:0]             ram_addr,
   output logic                   ram_rd,
   output logic                   ram_wr,
   output logic [7:0]             ram_wdata,
   input  logic [7:0]             ram_rdata,
   input  logic [NUM_CH-1:0]      pad_present,
   input  logic [NUM_CH-1:0]      accessory,
   input  logic [8*BTN_BYTES-1:0] buttons,
   output logic                   dev_tx_valid,
   output logic [7:0]             dev_tx_byte,
   output logic                   dev_req,
   output logic [5:0]             dev_chan,
   output logic [7:0]             dev_cmd,
   output logic [5:0]             dev_tx_len,
   output logic [5:0]             dev_rx_len,
   input  logic                   dev_done,
   input  logic                   dev_ok,
   output logic [5:0]             dev_rx_idx,
   input  logic [7:0]             dev_rx_byte
);
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int LAST  = DEPTH - 1;
   localparam int PW    = AW + 2;
   localparam int CH_W  = AW;
   localparam int LEN_W = AW;

   if (EXT_LO <= int'(CMD_BUTTONS) || EXT_HI >= int'(CMD_RESET) || EXT_LO > EXT_HI) begin : g_bad_ext
      $error("cmdblk_walker: external command range invalid");
   end

   walk_state_e      state;
   logic [PW-1:0]    ptr;
   logic [CH_W-1:0]  chan;
   logic [LEN_W-1:0] tx_len, cnt;
   logic [7:0]       rx_raw, cmd;
   logic [AW-1:0]    rx_addr;
   logic             use_ext, tx_in;

   len_class_e       hdr_cls;
   logic             bi_is, bi_ok;
   logic [7:0]       bi_byte;

   logic [LEN_W-1:0] rx_len;
   logic             ptr_in, ext_code, chan_ok;
   logic [7:0]       tx_byte, rep_byte;

   assign rx_len   = rx_raw[LEN_W-1:0];
   assign ptr_in   = ptr < PW'(DEPTH);
   assign ext_code = (int'(cmd) >= EXT_LO) && (int'(cmd) <= EXT_HI);
   assign chan_ok  = int'(chan) < NUM_CH;
   assign tx_byte  = tx_in ? ram_rdata : 8'h00;
   assign rep_byte = use_ext ? dev_rx_byte : bi_byte;

   cbw_len_classify u_cls (
      .len_byte (ram_rdata),
      .cls      (hdr_cls)
   );

   cbw_builtin #(
      .NUM_CH     (NUM_CH),
      .CH_W       (CH_W),
      .IDX_W      (LEN_W),
      .BTN_BYTES  (BTN_BYTES),
      .CH0_FORCED (CH0_FORCED),
      .ID_BYTE0   (ID_BYTE0),
      .ID_BYTE1   (ID_BYTE1)
   ) u_builtin (
      .chan        (chan),
      .cmd         (cmd),
      .idx         (cnt),
      .pad_present (pad_present),
      .accessory   (accessory),
      .buttons     (buttons),
      .is_builtin  (bi_is),
      .ok          (bi_ok),
      .reply_byte  (bi_byte)
   );

   // RAM port driving
   always_comb begin
      ram_rd    = 1'b0;
      ram_wr    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      case (state)
         S_CTL_RD, S_FIN_RD: begin
            ram_rd   = 1'b1;
            ram_addr = AW'(LAST);
         end
         S_HDR_RD: if (ptr < PW'(LAST)) begin
            ram_rd   = 1'b1;
            ram_addr = ptr[AW-1:0];
         end
         S_HDR_WT: if (hdr_cls == LEN_FRAME) begin
            ram_rd   = 1'b1;
            ram_addr = ptr[AW-1:0];
         end
         S_TX_RD: if (ptr_in) begin
            ram_rd   = 1'b1;
            ram_addr = ptr[AW-1:0];
         end
         S_REPLY: if (cnt != rx_len && ptr_in) begin
            ram_wr    = 1'b1;
            ram_addr  = ptr[AW-1:0];
            ram_wdata = rep_byte;
         end
         S_FAIL: begin
            ram_wr    = 1'b1;
            ram_addr  = rx_addr;
            ram_wdata = rx_raw | FAIL_MARK;
         end
         S_FIN_WT: begin
            ram_wr    = 1'b1;
            ram_addr  = AW'(LAST);
            ram_wdata = ram_rdata & 8'h7F;
         end
         default: ;
      endcase
   end

   assign busy         = (state != S_IDLE);
   assign done         = (state == S_DONE);
   assign dev_tx_valid = (state == S_TX_WT);
   assign dev_tx_byte  = tx_byte;
   assign dev_req      = (state == S_EXEC) && !bi_is && ext_code && chan_ok;
   assign dev_chan     = chan;
   assign dev_cmd      = cmd;
   assign dev_tx_len   = tx_len;
   assign dev_rx_len   = rx_len;
   assign dev_rx_idx   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         ptr     <= '0;
         chan    <= '0;
         tx_len  <= '0;
         cnt     <= '0;
         rx_raw  <= '0;
         cmd     <= '0;
         rx_addr <= '0;
         use_ext <= 1'b0;
         tx_in   <= 1'b0;
      end else begin
         case (state)
            S_IDLE:   if (start) state <= S_CTL_RD;
            S_CTL_RD: state <= S_CTL_WT;
            S_CTL_WT: begin
               if (ram_rdata == GATE_CODE) begin
                  ptr   <= '0;
                  chan  <= '0;
                  state <= S_HDR_RD;
               end else begin
                  state <= S_DONE;
               end
            end
            S_HDR_RD: begin
               if (ptr < PW'(LAST)) begin
                  ptr   <= ptr + 1'b1;
                  state <= S_HDR_WT;
               end else begin
                  state <= S_FIN_RD;
               end
            end
            S_HDR_WT: begin
               case (hdr_cls)
                  LEN_STOP:  state <= S_FIN_RD;
                  LEN_SKIP:  state <= S_HDR_RD;
                  LEN_EMPTY: begin
                     chan  <= chan + 1'b1;
                     state <= S_HDR_RD;
                  end
                  default: begin
                     tx_len  <= ram_rdata[LEN_W-1:0];
                     rx_addr <= ptr[AW-1:0];
                     ptr     <= ptr + 1'b1;
                     state   <= S_RXL_WT;
                  end
               endcase
            end
            S_RXL_WT: begin
               if (ram_rdata == STOP_CODE) begin
                  state <= S_FIN_RD;
               end else begin
                  rx_raw <= ram_rdata;
                  cnt    <= '0;
                  state  <= S_TX_RD;
               end
            end
            S_TX_RD: begin
               tx_in <= ptr_in;
               ptr   <= ptr + 1'b1;
               state <= S_TX_WT;
            end
            S_TX_WT: begin
               if (cnt == '0) cmd <= tx_byte;
               if (cnt + LEN_W'(1) == tx_len) begin
                  cnt   <= '0;
                  state <= S_EXEC;
               end else begin
                  cnt   <= cnt + 1'b1;
                  state <= S_TX_RD;
               end
            end
            S_EXEC: begin
               if (bi_is) begin
                  use_ext <= 1'b0;
                  state   <= bi_ok ? S_REPLY : S_FAIL;
               end else if (ext_code && chan_ok) begin
                  use_ext <= 1'b1;
                  state   <= S_DEV_WT;
               end else begin
                  state <= S_FAIL;
               end
            end
            S_DEV_WT: if (dev_done) state <= dev_ok ? S_REPLY : S_FAIL;
            S_REPLY: begin
               if (cnt == rx_len) begin
                  chan  <= chan + 1'b1;
                  state <= S_HDR_RD;
               end else begin
                  cnt <= cnt + 1'b1;
                  ptr <= ptr + 1'b1;
               end
            end
            S_FAIL: begin
               chan  <= chan + 1'b1;
               state <= S_HDR_RD;
            end
            S_FIN_RD: state <= S_FIN_WT;
            S_FIN_WT: state <= S_DONE;
            S_DONE:   state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end

   AST_GATE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CTL_WT && ram_rdata != GATE_CODE) |=> (done && !ram_wr)); // R1
   AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd && state == S_HDR_RD) |-> (ptr < PW'(LAST))); // R2
   AST_SKIP_KEEPS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HDR_WT && ram_rdata[7] && ram_rdata != STOP_CODE) |=> $stable(chan)); // R4
   AST_EMPTY_STEPS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_HDR_WT && (ram_rdata == 8'h00 || ram_rdata[7:6] == 2'b01))
      |=> (chan == $past(chan) + 1'b1)); // R5
   AST_FAIL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr && state == S_FAIL) |-> (ram_wdata[7] && ram_addr == rx_addr)); // R7
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |=> (!dev_req && busy)); // R10
   AST_FIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr && state == S_FIN_WT) |-> (!ram_wdata[7] && ram_addr == AW'(LAST))); // R12
endmodule

// File: tb/cmdblk_walker_bench.sv
module cmdblk_walker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done;
   logic [5:0] ram_addr;
   logic ram_rd, ram_wr;
   logic [7:0] ram_wdata;
   logic [7:0] ram_rdata = 8'h00;
   logic [NCH-1:0] pad_present = '0;
   logic [NCH-1:0] accessory = '0;
   logic [31:0] buttons = '0;
   logic dev_tx_valid, dev_req;
   logic [7:0] dev_tx_byte, dev_cmd;
   logic [5:0] dev_chan, dev_tx_len, dev_rx_len, dev_rx_idx;
   logic dev_done = 1'b0;
   logic dev_ok = 1'b0;
   logic [7:0] dev_rx_byte;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign dev_rx_byte = 8'hA0 + {2'b00, dev_rx_idx};

   cmdblk_walker u_cmdblk_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .pad_present(pad_present), .accessory(accessory), .buttons(buttons),
      .dev_tx_valid(dev_tx_valid), .dev_tx_byte(dev_tx_byte), .dev_req(dev_req),
      .dev_chan(dev_chan), .dev_cmd(dev_cmd), .dev_tx_len(dev_tx_len),
      .dev_rx_len(dev_rx_len), .dev_done(dev_done), .dev_ok(dev_ok),
      .dev_rx_idx(dev_rx_idx), .dev_rx_byte(dev_rx_byte)
   );

   // RAM model with bench loader
   logic [7:0] mem [64];
   logic       ld_en = 1'b0;
   logic [5:0] ld_addr = '0;
   logic [7:0] ld_data = '0;
   always @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      else if (ram_wr) mem[ram_addr] <= ram_wdata;
      if (ram_rd) ram_rdata <= mem[ram_addr];
   end

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] img [64];
   logic [7:0] exp_mem [64];
   logic [25:0] exp_q [$];

   task automatic chk(input bit good, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // monitor and external device model (R10)
   int pend = 0;
   bit pend_ok = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         dev_done = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               dev_done = 1'b1;
               dev_ok   = pend_ok;
            end
         end
         if (dev_req) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected request", {38'b0, dev_chan, dev_cmd, dev_tx_len, dev_rx_len}, 64'h0);
            end else begin
               logic [25:0] e;
               e = exp_q.pop_front();
               chk({dev_chan, dev_cmd, dev_tx_len, dev_rx_len} == e, "R10", "request fields",
                   {38'b0, dev_chan, dev_cmd, dev_tx_len, dev_rx_len}, {38'b0, e});
            end
            pend    = 3;
            pend_ok = (dev_cmd != 8'h03);
         end
      end
   end

   task automatic put(input int a, input logic [7:0] v);
      img[a] = v;
   endtask

   task automatic fill(input logic [7:0] v);
      for (int i = 0; i < 64; i++) img[i] = v;
   endtask

   // expected image from the requirements
   task automatic ref_walk();
      int p, ch, hdr, tl, rl;
      logic [7:0] t, r, c;
      logic [7:0] rep [64];
      bit ok;
      for (int i = 0; i < 64; i++) exp_mem[i] = img[i];
      if (exp_mem[63] != 8'h01) return;
      p = 0; ch = 0;
      while (p < 63) begin
         t = exp_mem[p]; p++;
         if (t == 8'hFE) break;
         if (t[7]) continue;
         if (t == 8'h00 || t[6]) begin ch++; continue; end
         hdr = p; r = exp_mem[p]; p++;
         if (r == 8'hFE) break;
         tl = int'(t); rl = int'(r[5:0]);
         c = (p < 64) ? exp_mem[p] : 8'h00;
         p += tl;
         for (int k = 0; k < 64; k++) rep[k] = 8'h00;
         if (c == 8'h00 || c == 8'hFF) begin
            ok = (ch == 0) || (ch < NCH && pad_present[ch]);
            rep[0] = 8'h05; rep[1] = 8'h00;
            rep[2] = (ch < NCH && accessory[ch]) ? 8'h01 : 8'h00;
         end else if (c == 8'h01) begin
            ok = (ch == 0);
            for (int k = 0; k < 4; k++) rep[k] = buttons[8*(3-k) +: 8];
         end else if (c >= 8'h02 && c <= 8'h08 && ch < NCH) begin
            ok = (c != 8'h03);
            for (int k = 0; k < 64; k++) rep[k] = 8'hA0 + 8'(k);
            exp_q.push_back({6'(ch), c, 6'(tl), 6'(rl)});
         end else begin
            ok = 1'b0;
         end
         if (ok) begin
            for (int k = 0; k < rl; k++) begin
               if (p < 64) exp_mem[p] = rep[k];
               p++;
            end
         end else begin
            exp_mem[hdr] = exp_mem[hdr] | 8'h80;
         end
         ch++;
      end
      exp_mem[63] = exp_mem[63] & 8'h7F;
   endtask

   task automatic run_case(input string tag);
      int cyc;
      int bad_at;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 6'(i); ld_data = img[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      ref_walk();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         chk(1'b0, tag, "watchdog expired", 64'(cyc), 64'd5000);
         return;
      end
      bad_at = -1;
      for (int i = 63; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad_at = i;
      if (bad_at < 0) chk(1'b1, tag, "image", 0, 0);
      else chk(1'b0, tag, $sformatf("image byte %0d", bad_at),
               64'(mem[bad_at]), 64'(exp_mem[bad_at]));
      chk(exp_q.size() == 0, tag, "requests outstanding", 64'(exp_q.size()), 64'd0);
      exp_q.delete();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !ram_wr && !dev_req, "R1", "reset outputs",
          {60'b0, busy, done, ram_wr, dev_req}, 64'h0);

      // R1: gate byte not 0x01, nothing written
      for (int i = 0; i < 64; i++) img[i] = 8'(i * 3);
      put(63, 8'h81);
      run_case("R1");

      // R8 status, R7 absent fails, R3 stop code, R2 frame walk
      fill(8'h55);
      put(0, 8'h01); put(1, 8'h03); put(2, 8'h00);
      put(6, 8'h01); put(7, 8'h03); put(8, 8'hFF);
      put(12, 8'h01); put(13, 8'h03); put(14, 8'h00);
      put(18, 8'hFE); put(63, 8'h01);
      pad_present = 5'b00100; accessory = 5'b00101;
      run_case("R8 R7 R3 R2");

      // R9 buttons, R5 empty, R4 skip, R7 pointer after failure
      fill(8'h55);
      put(0, 8'h01); put(1, 8'h04); put(2, 8'h01);
      put(7, 8'h00); put(8, 8'hFD);
      put(9, 8'h01); put(10, 8'h04); put(11, 8'h01);
      put(12, 8'h40);
      put(13, 8'h01); put(14, 8'h03); put(15, 8'h00);
      put(19, 8'hFE); put(63, 8'h01);
      pad_present = 5'b10000; accessory = 5'b00000; buttons = 32'h1234_5678;
      run_case("R9 R5 R4 R7");

      // R10 external, R11 unknown code and channel range, R3 receive stop
      fill(8'h55);
      put(0, 8'h03); put(1, 8'h02); put(2, 8'h02); put(3, 8'hAA); put(4, 8'hBB);
      put(7, 8'h02); put(8, 8'h01); put(9, 8'h03); put(10, 8'hCC);
      put(11, 8'h01); put(12, 8'h01); put(13, 8'h09);
      put(14, 8'h00); put(15, 8'h00);
      put(16, 8'h01); put(17, 8'h01); put(18, 8'h02);
      put(19, 8'h01); put(20, 8'hFE); put(63, 8'h01);
      pad_present = 5'b11111;
      run_case("R10 R11 R3");

      // R6: reply length from low six bits of the receive count
      fill(8'h55);
      put(0, 8'h01); put(1, 8'h43); put(2, 8'h00); put(6, 8'hFE); put(63, 8'h01);
      accessory = 5'b00001;
      run_case("R6");

      // R12 final clear after reply reaches byte 63, R2 walk ends at pointer bound
      fill(8'hFD);
      put(57, 8'h01); put(58, 8'h04); put(59, 8'h01); put(63, 8'h01);
      buttons = 32'hDEAD_BE9C;
      run_case("R12 R2");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL R2 global watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule